// File: doc/BRIEF.md
# Dual-Vector Command/Response Interrupt Handshake

This block is the host-side register and interrupt logic that sits between a host processor and a communications coprocessor. The host reaches it over a byte-wide register bus that offers plain writes, bit-set writes, bit-clear writes and non-modifying test accesses. Two bytes are visible: a control byte holding a run bit, a request-input bit and two interrupt enables, and a status byte holding a ready-for-input flag and a ready-for-output flag.

Commands flow from the host into a one-word holding register and on to the coprocessor over a valid/ready port. Responses flow from the coprocessor into a response register that the host reads. The block raises interrupts on two vectors. The command-input vector is tied to the ready-for-input flag. The response-output vector is tied to the ready-for-output flag and sits four above the input vector. When both are pending, the input vector is granted first. The acknowledge returns the vector of the granted request and retires that request. A request is also withdrawn as soon as the flag or enable behind it goes away.

Top module: `dualVecHandshake`

## Requirements
- R1: After reset both register bytes read 0x00, `irq` is low, `engCmdValid` is low and `engRspReady` is low.
- R2: Control byte (`csrAddr`=0) layout: bit 0 run, bit 1 request-input, bit 2 enable of the input vector, bit 3 enable of the output vector; bits 7:4 read 0. `csrOp` values: 0 writes the data, 1 ORs it in, 2 clears the bits set in it, 3 leaves the byte unchanged. `csrRdData` follows `csrAddr` in the same cycle.
- R3: Status byte (`csrAddr`=1) layout: bit 4 ready-for-input, bit 7 ready-for-output, all other bits 0. Ready-for-input is set one clock after run and request-input are both set while no command is held, and it clears one clock after request-input is cleared.
- R4: `cmdWe` loads `cmdWrData` only while ready-for-input is set. On that edge ready-for-input clears and `engCmdValid` rises with the word on `engCmdData`. A write while ready-for-input is clear is ignored. Ready-for-input returns one clock after the coprocessor takes the word, if run and request-input are still set.
- R5: `engRspReady` equals run AND NOT ready-for-output. An accepted response appears on `rspRdData` and sets ready-for-output on the same edge. A host write, set or clear to the status byte whose result has bit 7 at 0 clears ready-for-output. The host can never set it.
- R6: The input vector request rises one clock after ready-for-input and its enable are both set, with run set. The output vector request behaves the same way with ready-for-output and its enable. Either request drives `irq`.
- R7: `intVec` is `VEC_BASE` while the input request is granted and `VEC_BASE`+4 while the output request is granted. When both are pending, the input request wins.
- R8: `intAck` on an edge retires the request being granted. That request does not return while its qualifying condition stays true; it needs that condition to fall and rise again.
- R9: A pending request is withdrawn in the same cycle that its ready flag, its enable or run becomes clear.
- R10: With run clear, `irq` is low at once, both ready flags are clear one clock later, and `engRspReady` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csrWe | input | 1 | Register write strobe |
| csrAddr | input | 1 | 0 control byte, 1 status byte |
| csrOp | input | 2 | Write kind: 0 write, 1 set, 2 clear, 3 test |
| csrWrData | input | 8 | Write data or bit mask |
| csrRdData | output | 8 | Read data of the addressed byte |
| cmdWe | input | 1 | Host command write strobe |
| cmdWrData | input | DATA_W | Host command word |
| rspRdData | output | DATA_W | Last accepted response word |
| engCmdValid | output | 1 | Command held for the coprocessor |
| engCmdData | output | DATA_W | Held command word |
| engCmdReady | input | 1 | Coprocessor takes the command |
| engRspValid | input | 1 | Coprocessor offers a response |
| engRspData | input | DATA_W | Response word |
| engRspReady | output | 1 | Block can take a response |
| irq | output | 1 | Interrupt request |
| intAck | input | 1 | Interrupt acknowledge |
| intVec | output | VEC_W | Vector of the granted request |

## Verification
Control writes and response captures show up on the register read port one edge after the write. Ready-for-input follows a control write or a coprocessor accept one edge later, and an interrupt follows its qualifier by one more edge. A withdrawal or an acknowledge shows on `irq` right after the edge that causes it. The bench drives every input just after a falling edge and samples just after the next falling edge, so it counts whole clocks from each stimulus. Each check is placed at the exact clock where that count says the result is due, including checks that the result is not yet visible one clock early.

// File: rtl/hsPkg.sv
package hsPkg;
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_TEST  = 2'd3
  } csrOpE;

  localparam int CTL_RUN  = 0;
  localparam int CTL_REQ  = 1;
  localparam int CTL_IEA  = 2;
  localparam int CTL_IEB  = 3;
  localparam int CTL_W    = 4;
  localparam int ST_RDYI  = 4;
  localparam int ST_RDYO  = 7;
  localparam int NUM_VEC  = 2;
  localparam int VEC_STEP = 4;

  typedef struct packed {
    logic ieB;
    logic ieA;
    logic reqIn;
    logic run;
  } ctlBitsT;

  typedef struct packed {
    logic loadCmd;
    logic loadRsp;
  } strobeT;

  function automatic logic [7:0] applyOp(logic [7:0] old, logic [1:0] op, logic [7:0] wd);
    case (op)
      OP_WRITE: applyOp = wd;
      OP_SET:   applyOp = old | wd;
      OP_CLEAR: applyOp = old & ~wd;
      default:  applyOp = old;
    endcase
  endfunction
endpackage

// File: rtl/hsDatapath.sv
module hsDatapath import hsPkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csrWe,
  input  logic              csrAddr,
  input  logic [1:0]        csrOp,
  input  logic [7:0]        csrWrData,
  output logic [7:0]        csrRdData,
  input  logic [DATA_W-1:0] cmdWrData,
  input  logic [DATA_W-1:0] engRspData,
  output logic [DATA_W-1:0] engCmdData,
  output logic [DATA_W-1:0] rspRdData,
  input  strobeT            strb,
  input  logic              rdyIn,
  input  logic              rdyOut,
  output ctlBitsT           ctlBits,
  output logic              rdyOutClr
);
  logic [CTL_W-1:0]  ctlReg;
  logic [DATA_W-1:0] cmdReg;
  logic [DATA_W-1:0] rspReg;
  logic [7:0]        ctlByte;
  logic [7:0]        statByte;
  logic [7:0]        statNext;

  assign ctlByte  = {{(8-CTL_W){1'b0}}, ctlReg};
  assign statByte = 8'((rdyOut ? (1 << ST_RDYO) : 0) | (rdyIn ? (1 << ST_RDYI) : 0));
  assign statNext = applyOp(statByte, csrOp, csrWrData);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlReg <= '0;
    end else if (csrWe && !csrAddr) begin
      ctlReg <= CTL_W'(applyOp(ctlByte, csrOp, csrWrData));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg <= '0;
      rspReg <= '0;
    end else begin
      if (strb.loadCmd) cmdReg <= cmdWrData;
      if (strb.loadRsp) rspReg <= engRspData;
    end
  end

  assign rdyOutClr  = csrWe && csrAddr && rdyOut && !statNext[ST_RDYO];
  assign ctlBits    = ctlBitsT'(ctlReg);
  assign csrRdData  = csrAddr ? statByte : ctlByte;
  assign engCmdData = cmdReg;
  assign rspRdData  = rspReg;
endmodule

// File: rtl/hsCtrl.sv
module hsCtrl import hsPkg::*; #(
  parameter int             VEC_W    = 9,
  parameter logic [VEC_W-1:0] VEC_BASE = 9'o300
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlBitsT          ctlBits,
  input  logic             cmdWe,
  input  logic             rdyOutClr,
  input  logic             engCmdReady,
  input  logic             engRspValid,
  input  logic             intAck,
  output strobeT           strb,
  output logic             rdyIn,
  output logic             rdyOut,
  output logic             engCmdValid,
  output logic             engRspReady,
  output logic             irq,
  output logic [VEC_W-1:0] intVec
);
  localparam logic [VEC_W-1:0] VEC_OUT = VEC_BASE + VEC_W'(VEC_STEP);

  logic                holdFull;
  logic [NUM_VEC-1:0]  qual;
  logic [NUM_VEC-1:0]  qualPrev;
  logic [NUM_VEC-1:0]  pend;
  logic [NUM_VEC-1:0]  req;
  logic [NUM_VEC-1:0]  gnt;

  assign engRspReady  = ctlBits.run && !rdyOut;
  assign strb.loadCmd = cmdWe && rdyIn;
  assign strb.loadRsp = engRspValid && engRspReady;
  assign engCmdValid  = holdFull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdyIn    <= 1'b0;
      rdyOut   <= 1'b0;
      holdFull <= 1'b0;
    end else begin
      rdyIn    <= ctlBits.run && ctlBits.reqIn && !holdFull && !strb.loadCmd;
      rdyOut   <= ctlBits.run && (rdyOut ? !rdyOutClr : strb.loadRsp);
      holdFull <= strb.loadCmd || (holdFull && !engCmdReady);
    end
  end

  assign qual[0] = ctlBits.run && rdyIn  && ctlBits.ieA;
  assign qual[1] = ctlBits.run && rdyOut && ctlBits.ieB;
  assign req     = pend & qual;

  // Fixed priority: lowest index (input vector) wins.
  always_comb begin
    gnt = '0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (req[i] && gnt == '0) gnt[i] = 1'b1;
    end
  end

  generate
    for (genvar v = 0; v < NUM_VEC; v++) begin : gPend
      always_ff @(posedge clk) begin
        if (!rstN) begin
          pend[v]     <= 1'b0;
          qualPrev[v] <= 1'b0;
        end else begin
          qualPrev[v] <= qual[v];
          pend[v]     <= qual[v] && (pend[v] ? !(intAck && gnt[v]) : !qualPrev[v]);
        end
      end
    end
  endgenerate

  assign irq    = |req;
  assign intVec = gnt[0] ? VEC_BASE : VEC_OUT;
endmodule

// File: rtl/dualVecHandshake.sv
module dualVecHandshake import hsPkg::*; #(
  parameter int               DATA_W   = 8,
  parameter int               VEC_W    = 9,
  parameter logic [VEC_W-1:0] VEC_BASE = 9'o300
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csrWe,
  input  logic              csrAddr,
  input  logic [1:0]        csrOp,
  input  logic [7:0]        csrWrData,
  output logic [7:0]        csrRdData,
  input  logic              cmdWe,
  input  logic [DATA_W-1:0] cmdWrData,
  output logic [DATA_W-1:0] rspRdData,
  output logic              engCmdValid,
  output logic [DATA_W-1:0] engCmdData,
  input  logic              engCmdReady,
  input  logic              engRspValid,
  input  logic [DATA_W-1:0] engRspData,
  output logic              engRspReady,
  output logic              irq,
  input  logic              intAck,
  output logic [VEC_W-1:0]  intVec
);
  strobeT  strb;
  ctlBitsT ctlBits;
  logic    rdyIn;
  logic    rdyOut;
  logic    rdyOutClr;

  hsDatapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN),
    .csrWe(csrWe), .csrAddr(csrAddr), .csrOp(csrOp), .csrWrData(csrWrData),
    .csrRdData(csrRdData),
    .cmdWrData(cmdWrData), .engRspData(engRspData),
    .engCmdData(engCmdData), .rspRdData(rspRdData),
    .strb(strb), .rdyIn(rdyIn), .rdyOut(rdyOut),
    .ctlBits(ctlBits), .rdyOutClr(rdyOutClr)
  );

  hsCtrl #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) uCtrl (
    .clk(clk), .rstN(rstN),
    .ctlBits(ctlBits), .cmdWe(cmdWe), .rdyOutClr(rdyOutClr),
    .engCmdReady(engCmdReady), .engRspValid(engRspValid), .intAck(intAck),
    .strb(strb), .rdyIn(rdyIn), .rdyOut(rdyOut),
    .engCmdValid(engCmdValid), .engRspReady(engRspReady),
    .irq(irq), .intVec(intVec)
  );
endmodule

// File: rtl/hsChk.sv
module hsChk import hsPkg::*; (
  input logic    clk,
  input logic    rstN,
  input logic    cmdWe,
  input logic    rdyIn,
  input logic    rdyOut,
  input ctlBitsT ctlBits,
  input logic    irq,
  input logic    engCmdValid,
  input logic    engRspReady
);
  // R4
  cmd_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdWe && rdyIn |=> !rdyIn && engCmdValid);

  // R4
  cmd_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdWe && !rdyIn && !engCmdValid |=> !engCmdValid);

  // R5
  rsp_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdyOut |-> !engRspReady);

  // R9
  irq_qual_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ctlBits.run && ((rdyIn && ctlBits.ieA) || (rdyOut && ctlBits.ieB)));

  // R10
  run_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctlBits.run |=> !rdyIn && !rdyOut);
endmodule

bind dualVecHandshake hsChk uChk (
  .clk(clk), .rstN(rstN), .cmdWe(cmdWe), .rdyIn(rdyIn), .rdyOut(rdyOut),
  .ctlBits(ctlBits), .irq(irq), .engCmdValid(engCmdValid), .engRspReady(engRspReady)
);

// File: tb/sim_dualVecHandshake.sv
module sim_dualVecHandshake;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;
  localparam int VEC_W = 9;
  localparam logic [VEC_W-1:0] VBASE = 9'o300;
  localparam logic [VEC_W-1:0] VOUT  = 9'o304;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csrWe = 1'b0;
  logic csrAddr = 1'b0;
  logic [1:0] csrOp = 2'd0;
  logic [7:0] csrWrData = '0;
  logic [7:0] csrRdData;
  logic cmdWe = 1'b0;
  logic [DATA_W-1:0] cmdWrData = '0;
  logic [DATA_W-1:0] rspRdData;
  logic engCmdValid;
  logic [DATA_W-1:0] engCmdData;
  logic engCmdReady = 1'b0;
  logic engRspValid = 1'b0;
  logic [DATA_W-1:0] engRspData = '0;
  logic engRspReady;
  logic irq;
  logic intAck = 1'b0;
  logic [VEC_W-1:0] intVec;

  int testCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dualVecHandshake #(.DATA_W(DATA_W), .VEC_W(VEC_W), .VEC_BASE(VBASE)) u0 (
    .clk(clk), .rstN(rstN), .csrWe(csrWe), .csrAddr(csrAddr), .csrOp(csrOp),
    .csrWrData(csrWrData), .csrRdData(csrRdData), .cmdWe(cmdWe), .cmdWrData(cmdWrData),
    .rspRdData(rspRdData), .engCmdValid(engCmdValid), .engCmdData(engCmdData),
    .engCmdReady(engCmdReady), .engRspValid(engRspValid), .engRspData(engRspData),
    .engRspReady(engRspReady), .irq(irq), .intAck(intAck), .intVec(intVec)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] modelOp(logic [7:0] old, logic [1:0] op, logic [7:0] wd);
    logic [7:0] r;
    case (op)
      2'd0: r = wd;
      2'd1: r = old | wd;
      2'd2: r = old & ~wd;
      default: r = old;
    endcase
    return r & 8'h0F;
  endfunction

  task automatic csrWr(logic addr, logic [1:0] op, logic [7:0] data);
    csrWe = 1'b1; csrAddr = addr; csrOp = op; csrWrData = data;
    cyc(1);
    csrWe = 1'b0;
  endtask

  task automatic readByte(logic addr, output logic [7:0] val);
    csrAddr = addr;
    #1 val = csrRdData;
  endtask

  task automatic cmdWr(logic [7:0] data);
    cmdWe = 1'b1; cmdWrData = data;
    cyc(1);
    cmdWe = 1'b0;
  endtask

  task automatic rspPush(logic [7:0] data);
    engRspValid = 1'b1; engRspData = data;
    cyc(1);
    engRspValid = 1'b0;
  endtask

  task automatic ack();
    intAck = 1'b1;
    cyc(1);
    intAck = 1'b0;
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    logic [7:0] rb;
    logic [7:0] ctlModel;
    cyc(3);
    rstN = 1'b1;
    cyc(1);

    // R1 reset state
    readByte(1'b0, rb); check("R1 ctl", rb, 8'h00);
    readByte(1'b1, rb); check("R1 status", rb, 8'h00);
    check("R1 irq", irq, 0);
    check("R1 cmdValid", engCmdValid, 0);
    check("R1 rspReady", engRspReady, 0);

    // run + both enables, no request
    csrWr(1'b0, 2'd0, 8'h0D);
    cyc(1);
    readByte(1'b0, rb); check("R2 ctl write", rb, 8'h0D);
    readByte(1'b1, rb); check("R3 no req", rb, 8'h00);
    check("R5 rspReady", engRspReady, 1);

    // R3 request-input sets ready one clock later, R6 irq one more
    csrWr(1'b0, 2'd1, 8'h02);
    readByte(1'b1, rb); check("R3 early", rb, 8'h00);
    cyc(1);
    readByte(1'b1, rb); check("R3 rdyIn", rb, 8'h10);
    check("R6 irq not yet", irq, 0);
    cyc(1);
    check("R6 irq A", irq, 1);
    check("R7 vec A", intVec, VBASE);

    // R4 command take and ignore
    cmdWr(8'hA5);
    readByte(1'b1, rb); check("R4 rdyIn clr", rb, 8'h00);
    check("R9 irq withdrawn", irq, 0);
    check("R4 cmdValid", engCmdValid, 1);
    check("R4 cmdData", engCmdData, 8'hA5);
    cmdWr(8'h3C);
    check("R4 ignored write", engCmdData, 8'hA5);
    engCmdReady = 1'b1;
    cyc(1);
    engCmdReady = 1'b0;
    check("R4 drained", engCmdValid, 0);
    readByte(1'b1, rb); check("R4 rdyIn still low", rb, 8'h00);
    cyc(1);
    readByte(1'b1, rb); check("R4 rdyIn back", rb, 8'h10);
    cyc(1);
    check("R6 irq A again", irq, 1);

    // R8 acknowledge without repeat
    ack();
    check("R8 ack clears", irq, 0);
    cyc(3);
    check("R8 no repeat", irq, 0);

    // R5 response
    rspPush(8'h5A);
    readByte(1'b1, rb); check("R5 rdyOut", rb, 8'h90);
    check("R5 rspReady low", engRspReady, 0);
    check("R5 rspData", rspRdData, 8'h5A);
    check("R6 B not yet", irq, 0);
    cyc(1);
    check("R6 irq B", irq, 1);
    check("R7 vec B", intVec, VOUT);

    // R7 both pending: A wins
    csrWr(1'b0, 2'd2, 8'h02);
    cyc(1);
    readByte(1'b1, rb); check("R3 req clear", rb, 8'h80);
    csrWr(1'b0, 2'd1, 8'h02);
    cyc(2);
    check("R7 both irq", irq, 1);
    check("R7 A wins", intVec, VBASE);
    ack();
    check("R8 B remains", irq, 1);
    check("R7 vec B after", intVec, VOUT);
    ack();
    check("R8 all acked", irq, 0);

    // R5 host cannot set rdyOut, clear works
    csrWr(1'b1, 2'd2, 8'h80);
    readByte(1'b1, rb); check("R5 clear", rb, 8'h10);
    check("R5 rspReady back", engRspReady, 1);
    csrWr(1'b1, 2'd1, 8'h80);
    readByte(1'b1, rb); check("R5 no set", rb, 8'h10);
    csrWr(1'b1, 2'd0, 8'h90);
    readByte(1'b1, rb); check("R5 no write set", rb, 8'h10);

    // R9 withdrawal by clearing ready
    rspPush(8'h77);
    cyc(1);
    check("R6 irq B2", irq, 1);
    csrWr(1'b1, 2'd2, 8'h80);
    check("R9 ready withdraw", irq, 0);

    // R6 enable gating, R9 enable withdrawal
    csrWr(1'b0, 2'd2, 8'h08);
    rspPush(8'h11);
    cyc(2);
    check("R6 masked", irq, 0);
    readByte(1'b1, rb); check("R5 masked rdy", rb, 8'h90);
    csrWr(1'b0, 2'd1, 8'h08);
    cyc(1);
    check("R6 enable rise", irq, 1);
    check("R7 vec B3", intVec, VOUT);
    csrWr(1'b0, 2'd2, 8'h08);
    check("R9 enable withdraw", irq, 0);

    // R10 run low
    csrWr(1'b0, 2'd1, 8'h08);
    cyc(1);
    check("R6 irq B4", irq, 1);
    csrWr(1'b0, 2'd2, 8'h01);
    check("R10 irq low", irq, 0);
    check("R10 rspReady", engRspReady, 0);
    cyc(1);
    readByte(1'b1, rb); check("R10 flags clear", rb, 8'h00);
    readByte(1'b0, rb); check("R2 ctl after", rb, 8'h0E);

    // R2 test op and upper bits
    csrWr(1'b0, 2'd3, 8'hFF);
    readByte(1'b0, rb); check("R2 test op", rb, 8'h0E);
    csrWr(1'b0, 2'd0, 8'hF2);
    readByte(1'b0, rb); check("R2 upper zero", rb, 8'h02);

    // R2 random register operations
    ctlModel = 8'h02;
    void'($urandom(32'h1234));
    for (int i = 0; i < 200; i++) begin
      logic [1:0] op;
      logic [7:0] wd;
      op = 2'($urandom);
      wd = 8'($urandom);
      csrWr(1'b0, op, wd);
      ctlModel = modelOp(ctlModel, op, wd);
      readByte(1'b0, rb); check("R2 random", rb, ctlModel);
    end

    done = 1'b1;
    finishRun();
  end
endmodule